// File: doc/BRIEF.md
# Configurable GPIO Port Bank

This block is a byte-addressed bank of general-purpose I/O ports for a small 8-bit controller core. Three bidirectional ports (two 8 bits wide, one 4 bits wide) each own a data register, a direction/mode register and a read-only view of their pad levels. Each pin's two register bits together select its pad mode: floating input, input with weak pull-up, driven low or driven high. The block drives the pad controls for every pin: output enable, output level and pull-up enable.

The bank also has an 8-bit input-only port that can only be read, and an 8-bit output-only port whose register comes out of reset as all ones. On the wide bidirectional port "G", the top two pins can only be inputs. Writing the G data register with its top bit set sends a one-cycle halt request to the core. Pad levels pass through a two-flop synchronizer before they can be read. Read data is registered, so it follows the address by one clock.

Top module: `gpio_port_bank`

## Requirements
- R1: While reset is asserted and afterwards, until the first write, every data and mode register of ports L, G and C is zero. Every pad output enable, output level and pull-up enable of those ports is therefore 0, and `halt_req` and `bus_rdata` are 0.
- R2: For each pin of L, G and C, with mode bit m and data bit v: output enable is m, output level is v, and pull-up enable is (not m) and v. The encoding is (m,v): 00 floating input, 01 pulled-up input, 10 drive 0, 11 drive 1. A write changes the pads starting in the cycle after the write edge.
- R3: Address map (4-bit address): L data 0x0, L mode 0x1, L pins 0x2; G data 0x4, G mode 0x5, G pins 0x6; C data 0x8, C mode 0x9, C pins 0xA; D data 0xC; I pins 0xE. A write is taken when `bus_wr` is high at a rising clock edge.
- R4: `bus_rdata` is registered. After each edge it holds the contents of the location that `bus_addr` selected at that edge. Every address not listed in R3 reads as 0x00.
- R5: Port C keeps only bits 3:0. Reads of its data, mode and pin locations return 0 in bits 7:4, and write data in bits 7:4 is dropped.
- R6: G mode bits 6 and 7 always read as 0, and writing ones to them has no effect. The output enable of G pins 6 and 7 is always 0.
- R7: A write to G data (0x4) with bit 7 set makes `halt_req` high for exactly the cycle that follows that edge. `halt_req` is low at all other times.
- R8: The D register is set to 0xFF by reset, drives `d_pad_out` directly, is writable at 0xC and reads back there.
- R9: A pad level sampled at edge k passes through a two-flop synchronizer and appears in the pin location's `bus_rdata` after edge k+2.
- R10: Pin locations (0x2, 0x6, 0xA, 0xE) are read-only. Writes to them change no register or pad output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 4 | Register address |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data |
| l_pad_in | input | 8 | Port L pad levels |
| l_pad_oe | output | 8 | Port L output enables |
| l_pad_out | output | 8 | Port L output levels |
| l_pad_pu | output | 8 | Port L pull-up enables |
| g_pad_in | input | 8 | Port G pad levels |
| g_pad_oe | output | 8 | Port G output enables |
| g_pad_out | output | 8 | Port G output levels |
| g_pad_pu | output | 8 | Port G pull-up enables |
| c_pad_in | input | 4 | Port C pad levels |
| c_pad_oe | output | 4 | Port C output enables |
| c_pad_out | output | 4 | Port C output levels |
| c_pad_pu | output | 4 | Port C pull-up enables |
| i_pad_in | input | 8 | Input-only port levels |
| d_pad_out | output | 8 | Output-only port levels |
| halt_req | output | 1 | One-cycle halt request to the core |

## Verification
The assertions assume that `bus_addr`, `bus_wr` and `bus_wdata` are stable and known at every rising edge once reset has been released. They also assume that reset is held for at least one edge at start-up. The stimulus meets both conditions: it changes bus and pad inputs one time unit after a falling edge, and it holds reset low for several cycles before the first access. Pad inputs may change freely because they pass through the synchronizer. The bench changes them only between edges so that its reference model can predict the two-cycle latency exactly.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;
    localparam int ADDR_W = 4;
    localparam int DATA_W = 8;

    localparam logic [ADDR_W-1:0] A_L_DATA = 4'h0;
    localparam logic [ADDR_W-1:0] A_L_MODE = 4'h1;
    localparam logic [ADDR_W-1:0] A_L_PIN  = 4'h2;
    localparam logic [ADDR_W-1:0] A_G_DATA = 4'h4;
    localparam logic [ADDR_W-1:0] A_G_MODE = 4'h5;
    localparam logic [ADDR_W-1:0] A_G_PIN  = 4'h6;
    localparam logic [ADDR_W-1:0] A_C_DATA = 4'h8;
    localparam logic [ADDR_W-1:0] A_C_MODE = 4'h9;
    localparam logic [ADDR_W-1:0] A_C_PIN  = 4'hA;
    localparam logic [ADDR_W-1:0] A_D_DATA = 4'hC;
    localparam logic [ADDR_W-1:0] A_I_PIN  = 4'hE;

    function automatic logic addr_mapped(input logic [ADDR_W-1:0] a);
        return (a == A_L_DATA) || (a == A_L_MODE) || (a == A_L_PIN) ||
               (a == A_G_DATA) || (a == A_G_MODE) || (a == A_G_PIN) ||
               (a == A_C_DATA) || (a == A_C_MODE) || (a == A_C_PIN) ||
               (a == A_D_DATA) || (a == A_I_PIN);
    endfunction

    function automatic logic addr_is_c(input logic [ADDR_W-1:0] a);
        return (a == A_C_DATA) || (a == A_C_MODE) || (a == A_C_PIN);
    endfunction
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_in,
    output logic [W-1:0] sync_out
);
    typedef struct packed {
        logic [W-1:0] meta;
        logic [W-1:0] stable;
    } sync_t;

    sync_t st_d, st_q;

    always_comb begin
        st_d        = st_q;
        st_d.meta   = async_in;
        st_d.stable = st_q.meta;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign sync_out = st_q.stable;

    // R9: the output moves only to the value held in the first stage one cycle earlier
    assert_sync_stage_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sync_out) |-> (sync_out == $past(st_q.meta)));
endmodule

// File: rtl/gpio_bidir_port.sv
module gpio_bidir_port #(
    parameter int           W       = 8,
    parameter logic [W-1:0] IN_ONLY = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_data,
    input  logic         wr_mode,
    input  logic [W-1:0] wdata,
    input  logic [W-1:0] pad_in,
    output logic [W-1:0] data_q,
    output logic [W-1:0] mode_q,
    output logic [W-1:0] pin_level,
    output logic [W-1:0] pad_oe,
    output logic [W-1:0] pad_out,
    output logic [W-1:0] pad_pu
);
    localparam logic [W-1:0] MODE_KEEP = ~IN_ONLY;

    typedef struct packed {
        logic [W-1:0] data;
        logic [W-1:0] mode;
    } port_t;

    port_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_data) st_d.data = wdata;
        if (wr_mode) st_d.mode = wdata & MODE_KEEP;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign data_q = st_q.data;
    assign mode_q = st_q.mode;

    for (genvar i = 0; i < W; i++) begin : g_pad
        if (IN_ONLY[i]) begin : g_in_only
            assign pad_oe[i] = 1'b0;
        end else begin : g_bidir
            assign pad_oe[i] = st_q.mode[i];
        end
        assign pad_out[i] = st_q.data[i];
        assign pad_pu[i]  = ~st_q.mode[i] & st_q.data[i];
    end

    gpio_sync #(.W(W)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (pad_in),
        .sync_out (pin_level)
    );

    // R6: input-only pins never hold a mode bit after a mode write
    assert_mode_mask_R6: assert property (@(posedge clk) disable iff (!rst_n)
        wr_mode |=> ((mode_q & IN_ONLY) == '0));
    // R2: mode register only changes on a mode write
    assert_mode_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_mode |=> $stable(mode_q));
    // R2: a written mode value shows on the output enables next cycle
    assert_oe_follow_R2: assert property (@(posedge clk) disable iff (!rst_n)
        wr_mode |=> (pad_oe == ($past(wdata) & MODE_KEEP)));
endmodule

// File: rtl/gpio_port_bank.sv
module gpio_port_bank
    import gpio_bank_pkg::*;
#(
    parameter int WIDE_W   = 8,
    parameter int NARROW_W = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [ADDR_W-1:0]   bus_addr,
    input  logic                bus_wr,
    input  logic [DATA_W-1:0]   bus_wdata,
    output logic [DATA_W-1:0]   bus_rdata,
    input  logic [WIDE_W-1:0]   l_pad_in,
    output logic [WIDE_W-1:0]   l_pad_oe,
    output logic [WIDE_W-1:0]   l_pad_out,
    output logic [WIDE_W-1:0]   l_pad_pu,
    input  logic [WIDE_W-1:0]   g_pad_in,
    output logic [WIDE_W-1:0]   g_pad_oe,
    output logic [WIDE_W-1:0]   g_pad_out,
    output logic [WIDE_W-1:0]   g_pad_pu,
    input  logic [NARROW_W-1:0] c_pad_in,
    output logic [NARROW_W-1:0] c_pad_oe,
    output logic [NARROW_W-1:0] c_pad_out,
    output logic [NARROW_W-1:0] c_pad_pu,
    input  logic [WIDE_W-1:0]   i_pad_in,
    output logic [WIDE_W-1:0]   d_pad_out,
    output logic                halt_req
);
    localparam int HALT_BIT = WIDE_W - 1;
    localparam logic [WIDE_W-1:0] G_IN_ONLY = {2'b11, {(WIDE_W-2){1'b0}}};

    typedef struct packed {
        logic [WIDE_W-1:0] d_reg;
        logic              halt;
        logic [DATA_W-1:0] rdata;
    } top_t;

    top_t st_d, st_q;

    logic [WIDE_W-1:0]   l_data, l_mode, l_pins;
    logic [WIDE_W-1:0]   g_data, g_mode, g_pins;
    logic [NARROW_W-1:0] c_data, c_mode, c_pins;
    logic [WIDE_W-1:0]   i_pins;

    logic wr_l_data, wr_l_mode, wr_g_data, wr_g_mode, wr_c_data, wr_c_mode, wr_d;

    always_comb begin
        wr_l_data = bus_wr && (bus_addr == A_L_DATA);
        wr_l_mode = bus_wr && (bus_addr == A_L_MODE);
        wr_g_data = bus_wr && (bus_addr == A_G_DATA);
        wr_g_mode = bus_wr && (bus_addr == A_G_MODE);
        wr_c_data = bus_wr && (bus_addr == A_C_DATA);
        wr_c_mode = bus_wr && (bus_addr == A_C_MODE);
        wr_d      = bus_wr && (bus_addr == A_D_DATA);
    end

    gpio_bidir_port #(.W(WIDE_W), .IN_ONLY('0)) u_port_l (
        .clk(clk), .rst_n(rst_n), .wr_data(wr_l_data), .wr_mode(wr_l_mode),
        .wdata(bus_wdata[WIDE_W-1:0]), .pad_in(l_pad_in),
        .data_q(l_data), .mode_q(l_mode), .pin_level(l_pins),
        .pad_oe(l_pad_oe), .pad_out(l_pad_out), .pad_pu(l_pad_pu)
    );

    gpio_bidir_port #(.W(WIDE_W), .IN_ONLY(G_IN_ONLY)) u_port_g (
        .clk(clk), .rst_n(rst_n), .wr_data(wr_g_data), .wr_mode(wr_g_mode),
        .wdata(bus_wdata[WIDE_W-1:0]), .pad_in(g_pad_in),
        .data_q(g_data), .mode_q(g_mode), .pin_level(g_pins),
        .pad_oe(g_pad_oe), .pad_out(g_pad_out), .pad_pu(g_pad_pu)
    );

    gpio_bidir_port #(.W(NARROW_W), .IN_ONLY('0)) u_port_c (
        .clk(clk), .rst_n(rst_n), .wr_data(wr_c_data), .wr_mode(wr_c_mode),
        .wdata(bus_wdata[NARROW_W-1:0]), .pad_in(c_pad_in),
        .data_q(c_data), .mode_q(c_mode), .pin_level(c_pins),
        .pad_oe(c_pad_oe), .pad_out(c_pad_out), .pad_pu(c_pad_pu)
    );

    gpio_sync #(.W(WIDE_W)) u_sync_i (
        .clk(clk), .rst_n(rst_n), .async_in(i_pad_in), .sync_out(i_pins)
    );

    always_comb begin
        st_d      = st_q;
        st_d.halt = wr_g_data && bus_wdata[HALT_BIT];
        if (wr_d) st_d.d_reg = bus_wdata[WIDE_W-1:0];
        case (bus_addr)
            A_L_DATA: st_d.rdata = DATA_W'(l_data);
            A_L_MODE: st_d.rdata = DATA_W'(l_mode);
            A_L_PIN:  st_d.rdata = DATA_W'(l_pins);
            A_G_DATA: st_d.rdata = DATA_W'(g_data);
            A_G_MODE: st_d.rdata = DATA_W'(g_mode);
            A_G_PIN:  st_d.rdata = DATA_W'(g_pins);
            A_C_DATA: st_d.rdata = DATA_W'(c_data);
            A_C_MODE: st_d.rdata = DATA_W'(c_mode);
            A_C_PIN:  st_d.rdata = DATA_W'(c_pins);
            A_D_DATA: st_d.rdata = DATA_W'(st_q.d_reg);
            A_I_PIN:  st_d.rdata = DATA_W'(i_pins);
            default:  st_d.rdata = '0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.d_reg <= '1;
            st_q.halt  <= 1'b0;
            st_q.rdata <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign bus_rdata = st_q.rdata;
    assign d_pad_out = st_q.d_reg;
    assign halt_req  = st_q.halt;

    // R7: a halt request only follows a G data write with the top bit set
    assert_halt_cause_R7: assert property (@(posedge clk) disable iff (!rst_n)
        halt_req |-> ($past(bus_wr) && ($past(bus_addr) == A_G_DATA) && $past(bus_wdata[HALT_BIT])));
    // R7: such a write always produces the request
    assert_halt_fire_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && (bus_addr == A_G_DATA) && bus_wdata[HALT_BIT]) |=> halt_req);
    // R4: unmapped addresses return zero
    assert_unmapped_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !addr_mapped($past(bus_addr)) |-> (bus_rdata == '0));
    // R5: narrow port reads have clear upper bits
    assert_c_upper_R5: assert property (@(posedge clk) disable iff (!rst_n)
        addr_is_c($past(bus_addr)) |-> (bus_rdata[DATA_W-1:NARROW_W] == '0));
    // R8: output-only port leaves reset at all ones
    assert_d_preset_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rst_n) |-> (d_pad_out == '1));
    // R6: input-only G pins are never enabled as outputs
    assert_g_hi_oe_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (g_pad_oe & G_IN_ONLY) == '0);
endmodule

// File: tb/gpio_port_bank_test.sv
`timescale 1ns/1ps
module gpio_port_bank_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] bus_addr = 4'h0;
    logic       bus_wr = 1'b0;
    logic [7:0] bus_wdata = 8'h00;
    logic [7:0] bus_rdata;
    logic [7:0] l_pad_in = 8'h00, g_pad_in = 8'h00, i_pad_in = 8'h00;
    logic [3:0] c_pad_in = 4'h0;
    logic [7:0] l_pad_oe, l_pad_out, l_pad_pu, g_pad_oe, g_pad_out, g_pad_pu, d_pad_out;
    logic [3:0] c_pad_oe, c_pad_out, c_pad_pu;
    logic       halt_req;

    int total = 0;
    int bad = 0;
    int cycles = 0;
    bit done = 0;

    always #2 clk = ~clk;

    gpio_port_bank uut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .l_pad_in(l_pad_in), .l_pad_oe(l_pad_oe), .l_pad_out(l_pad_out), .l_pad_pu(l_pad_pu),
        .g_pad_in(g_pad_in), .g_pad_oe(g_pad_oe), .g_pad_out(g_pad_out), .g_pad_pu(g_pad_pu),
        .c_pad_in(c_pad_in), .c_pad_oe(c_pad_oe), .c_pad_out(c_pad_out), .c_pad_pu(c_pad_pu),
        .i_pad_in(i_pad_in), .d_pad_out(d_pad_out), .halt_req(halt_req)
    );

    // behavioural reference model
    logic [7:0] m_ld, m_lm, m_gd, m_gm, m_d, m_rd;
    logic [3:0] m_cd, m_cm;
    logic [7:0] m_l1, m_l2, m_g1, m_g2, m_i1, m_i2;
    logic [3:0] m_c1, m_c2;
    logic       m_halt;

    function automatic logic [7:0] model_read(input logic [3:0] a);
        case (a)
            4'h0: return m_ld;
            4'h1: return m_lm;
            4'h2: return m_l2;
            4'h4: return m_gd;
            4'h5: return m_gm;
            4'h6: return m_g2;
            4'h8: return {4'h0, m_cd};
            4'h9: return {4'h0, m_cm};
            4'hA: return {4'h0, m_c2};
            4'hC: return m_d;
            4'hE: return m_i2;
            default: return 8'h00;
        endcase
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_ld = 0; m_lm = 0; m_gd = 0; m_gm = 0; m_cd = 0; m_cm = 0;
            m_d = 8'hFF; m_rd = 0; m_halt = 0;
            m_l1 = 0; m_l2 = 0; m_g1 = 0; m_g2 = 0; m_c1 = 0; m_c2 = 0; m_i1 = 0; m_i2 = 0;
        end else begin
            m_rd   = model_read(bus_addr);
            m_halt = bus_wr && bus_addr == 4'h4 && bus_wdata[7];
            m_l2 = m_l1; m_l1 = l_pad_in;
            m_g2 = m_g1; m_g1 = g_pad_in;
            m_c2 = m_c1; m_c1 = c_pad_in;
            m_i2 = m_i1; m_i1 = i_pad_in;
            if (bus_wr) begin
                case (bus_addr)
                    4'h0: m_ld = bus_wdata;
                    4'h1: m_lm = bus_wdata;
                    4'h4: m_gd = bus_wdata;
                    4'h5: m_gm = bus_wdata & 8'h3F;
                    4'h8: m_cd = bus_wdata[3:0];
                    4'h9: m_cm = bus_wdata[3:0];
                    4'hC: m_d  = bus_wdata;
                    default: ;
                endcase
            end
        end
    end

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    // compare against the model on every falling edge
    always @(negedge clk) begin
        if (rst_n && !done) begin
            chk("R2 l_oe", l_pad_oe, m_lm);
            chk("R2 l_out", l_pad_out, m_ld);
            chk("R2 l_pu", l_pad_pu, ~m_lm & m_ld);
            chk("R2 g_oe", g_pad_oe, m_gm);
            chk("R2 g_out", g_pad_out, m_gd);
            chk("R2 g_pu", g_pad_pu, ~m_gm & m_gd);
            chk("R2 c_oe", {4'h0, c_pad_oe}, {4'h0, m_cm});
            chk("R2 c_out", {4'h0, c_pad_out}, {4'h0, m_cd});
            chk("R2 c_pu", {4'h0, c_pad_pu}, {4'h0, ~m_cm & m_cd});
            chk("R4 rdata", bus_rdata, m_rd);
            chk("R7 halt", {7'h0, halt_req}, {7'h0, m_halt});
            chk("R8 d_out", d_pad_out, m_d);
        end
    end

    logic last_halt;

    task automatic bus_write(input logic [3:0] a, input logic [7:0] v);
        @(negedge clk); #1;
        bus_addr = a; bus_wr = 1'b1; bus_wdata = v;
        @(negedge clk);
        last_halt = halt_req;
        #1 bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [3:0] a, output logic [7:0] v);
        @(negedge clk); #1;
        bus_addr = a;
        repeat (3) @(negedge clk);
        v = bus_rdata;
    endtask

    initial begin : watchdog
        while (!done && cycles < 100000) begin
            @(posedge clk);
            cycles++;
        end
        if (!done) begin
            done = 1;
            total++; bad++;
            $display("FAIL watchdog actual=%0d expected=<100000", cycles);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin : stim
        logic [7:0] v;
        repeat (5) @(negedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        chk("R1 l_oe", l_pad_oe, 8'h00);
        chk("R1 g_pu", g_pad_pu, 8'h00);
        chk("R1 c_out", {4'h0, c_pad_out}, 8'h00);
        chk("R1 rdata", bus_rdata, 8'h00);
        chk("R8 reset preset", d_pad_out, 8'hFF);

        // R2 / R3: four modes on port L
        bus_write(4'h1, 8'hF0);
        bus_write(4'h0, 8'hCC);
        @(negedge clk);
        chk("R2 mode oe", l_pad_oe, 8'hF0);
        chk("R2 mode pu", l_pad_pu, 8'h0C);
        chk("R2 mode out", l_pad_out, 8'hCC);
        bus_read(4'h0, v); chk("R3 L data readback", v, 8'hCC);
        bus_read(4'h1, v); chk("R3 L mode readback", v, 8'hF0);

        // R6: G high pins input-only
        bus_write(4'h5, 8'hFF);
        bus_read(4'h5, v); chk("R6 G mode read", v, 8'h3F);
        chk("R6 G oe", g_pad_oe, 8'h3F);

        // R7: halt pulse
        bus_write(4'h4, 8'h80);
        chk("R7 halt pulse", {7'h0, last_halt}, 8'h01);
        @(negedge clk);
        chk("R7 halt one cycle", {7'h0, halt_req}, 8'h00);
        bus_write(4'h4, 8'h7F);
        chk("R7 no halt", {7'h0, last_halt}, 8'h00);
        bus_write(4'h0, 8'h80);
        chk("R7 other address", {7'h0, last_halt}, 8'h00);
        bus_write(4'h0, 8'hCC);

        // R5: narrow port
        bus_write(4'h8, 8'hFA);
        bus_read(4'h8, v); chk("R5 C data", v, 8'h0A);
        bus_write(4'h9, 8'hF5);
        bus_read(4'h9, v); chk("R5 C mode", v, 8'h05);
        c_pad_in = 4'hF;
        bus_read(4'hA, v); chk("R5 C pins", v, 8'h0F);

        // R8: output-only port
        bus_write(4'hC, 8'h5A);
        chk("R8 d write", d_pad_out, 8'h5A);
        bus_read(4'hC, v); chk("R8 d readback", v, 8'h5A);

        // R9: synchronizer latency on L pins
        bus_read(4'h2, v); chk("R9 L pins idle", v, 8'h00);
        @(negedge clk); #1 l_pad_in = 8'h69;
        @(negedge clk); chk("R9 after one edge", bus_rdata, 8'h00);
        @(negedge clk); chk("R9 after two edges", bus_rdata, 8'h00);
        @(negedge clk); chk("R9 after three edges", bus_rdata, 8'h69);

        // R10: pin locations read-only
        i_pad_in = 8'hA5;
        bus_write(4'hE, 8'h00);
        bus_write(4'h2, 8'h00);
        bus_write(4'h6, 8'hFF);
        bus_read(4'hE, v); chk("R10 I pins", v, 8'hA5);
        chk("R10 L out kept", l_pad_out, 8'hCC);
        chk("R10 G oe kept", g_pad_oe, 8'h3F);
        g_pad_in = 8'h3C;
        bus_read(4'h6, v); chk("R10 G pins", v, 8'h3C);

        // R4: unmapped addresses
        bus_read(4'h3, v); chk("R4 unmapped 3", v, 8'h00);
        bus_read(4'hF, v); chk("R4 unmapped F", v, 8'h00);
        bus_write(4'h7, 8'hFF);
        bus_read(4'h7, v); chk("R4 unmapped 7", v, 8'h00);

        // further pattern sweep against the model
        for (int k = 0; k < 40; k++) begin
            bus_write(4'(k % 16), 8'((k * 37) ^ 8'h5C));
            l_pad_in = 8'(k * 13);
            g_pad_in = 8'(k * 7);
        end
        repeat (4) @(negedge clk);

        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule